// File: doc/BRIEF.md
# Dual-Clock Mailbox Pair

This block gives two ports, each on its own free-running clock, a way to hand a single word to each other outside any data queue. It has two one-word registers. One carries a message from port A to port B, and the other carries a message from port B to port A. The side that writes a register owns it until the other side has taken the word. The port clocks may be unrelated, so every hand-over is signalled with a toggle that crosses into the other clock domain through a chain of synchronizer flops.

Each receiving port sees an active-low flag that falls when fresh mail is waiting. The receiver reads the word and pulses a read to take it, and that read raises the flag on its next clock edge. The sender does not treat the register as free until the read toggle has come back through its own synchronizer. A write made while the register is still owned is dropped. Every access is qualified by the port's select input, so when select is low the port's write and read strobes belong to other logic and leave both registers untouched.

Top module: `mbox_pair`

## Requirements
- R1: While rst_n is low and after it is released, both mail_a_n and mail_b_n are 1 (no mail), and both dout_a and dout_b read all zeros.
- R2: A write from port A (sel_a=1, wr_a=1 at a clk_a rising edge) into a free register captures din_a. mail_b_n then falls within SYNC_STAGES+1 clk_b edges, and dout_b shows the captured word while mail_b_n is 0.
- R3: A read by port B (sel_b=1, rd_b=1) while mail_b_n is 0 sets mail_b_n to 1 at that clk_b edge.
- R4: A write into a register whose previous word has not been read and acknowledged back to the sender is ignored. The stored word is kept and no new mail is signalled.
- R5: The B-to-A register behaves the same way with the roles swapped: wr_b/din_b write it, mail_a_n flags it, dout_a shows the word, and rd_a takes it.
- R6: A write or read strobe with the port's select low has no effect on either register or flag.
- R7: A read while the flag shows no mail has no effect. A later valid write still raises the flag.
- R8: Once mail is flagged, the flag stays low and the output word stays unchanged until the receiver reads it.
- R9: The two directions are independent. Traffic in one never changes the flag or word of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, unrelated to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sel_a | input | 1 | Port A mailbox select, qualifies wr_a and rd_a |
| wr_a | input | 1 | Port A write strobe (A-to-B register) |
| rd_a | input | 1 | Port A read strobe (B-to-A register) |
| din_a | input | W | Word written by port A |
| dout_a | output | W | Word held in the B-to-A register |
| mail_a_n | output | 1 | Low when mail from B waits for A |
| sel_b | input | 1 | Port B mailbox select, qualifies wr_b and rd_b |
| wr_b | input | 1 | Port B write strobe (B-to-A register) |
| rd_b | input | 1 | Port B read strobe (A-to-B register) |
| din_b | input | W | Word written by port B |
| dout_b | output | W | Word held in the A-to-B register |
| mail_b_n | output | 1 | Low when mail from A waits for B |

## Verification
The assertions assume that strobes are synchronous to their own port clock and that rst_n is released away from both clock edges. The stable-word check also assumes that a sender's register changes only through an accepted write, so it holds only while the receiver's flag is low. The bench drives every strobe and data change on the falling edge of the port clock that owns it, and releases reset between edges. It samples flags only after counting enough edges of the receiving clock to cover the synchronizer depth, so no check depends on where one clock's edges fall relative to the other's.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   // Direction index used by the generate loop in the top
   localparam int unsigned DIR_A2B = 0;
   localparam int unsigned DIR_B2A = 1;
   localparam int unsigned NUM_DIR = 2;
   // Fewest flops that make a usable synchronizer
   localparam int unsigned MIN_SYNC = 2;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   import mbox_pkg::*;

   generate
      if (STAGES < MIN_SYNC) begin : g_bad
         $error("mbox_sync: STAGES below minimum");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_tx.sv
module mbox_tx #(
   parameter int unsigned W      = 36,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] din,
   input  logic         ack_tog,
   output logic [W-1:0] word,
   output logic         req_tog
);
   logic ack_s;
   logic busy;

   mbox_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(clk), .rst_n(rst_n), .d(ack_tog), .q(ack_s)
   );

   assign busy = req_tog ^ ack_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word    <= '0;
         req_tog <= 1'b0;
      end else if (wr && !busy) begin
         word    <= din;
         req_tog <= ~req_tog;
      end
   end

   // R2
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !busy) |=> busy);
   // R4
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && busy) |=> ($stable(word) && $stable(req_tog)));
endmodule

// File: rtl/mbox_rx.sv
module mbox_rx #(
   parameter int unsigned W      = 36,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd,
   input  logic         req_tog,
   input  logic [W-1:0] word,
   output logic         ack_tog,
   output logic         mail_n
);
   logic req_s;
   logic full;

   mbox_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n), .d(req_tog), .q(req_s)
   );

   assign full   = req_s ^ ack_tog;
   assign mail_n = ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ack_tog <= 1'b0;
      else if (rd && full) ack_tog <= ~ack_tog;
   end

   // R3
   read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && full) |=> mail_n);
   // R8
   mail_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd) |=> !mail_n);
   // R8
   word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd && $past(full)) |-> $stable(word));
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair #(
   parameter int unsigned W           = 36,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         clk_a,
   input  logic         clk_b,
   input  logic         rst_n,
   input  logic         sel_a,
   input  logic         wr_a,
   input  logic         rd_a,
   input  logic [W-1:0] din_a,
   output logic [W-1:0] dout_a,
   output logic         mail_a_n,
   input  logic         sel_b,
   input  logic         wr_b,
   input  logic         rd_b,
   input  logic [W-1:0] din_b,
   output logic [W-1:0] dout_b,
   output logic         mail_b_n
);
   import mbox_pkg::*;

   generate
      if (W < 1) begin : g_bad_w
         $error("mbox_pair: W must be positive");
      end
   endgenerate

   // Index by port: 0 = A, 1 = B
   logic [NUM_DIR-1:0]        clk_v, wr_v, rd_v, mail_v;
   logic [NUM_DIR-1:0][W-1:0] din_v, word_v;
   logic [NUM_DIR-1:0]        req_v, ack_v;

   assign clk_v = {clk_b, clk_a};
   assign wr_v  = {sel_b & wr_b, sel_a & wr_a};
   assign rd_v  = {sel_b & rd_b, sel_a & rd_a};
   assign din_v = {din_b, din_a};

   // Channel d is sent by port d and received by the other port
   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      localparam int unsigned RX = NUM_DIR - 1 - d;

      mbox_tx #(.W(W), .STAGES(SYNC_STAGES)) u_tx (
         .clk(clk_v[d]), .rst_n(rst_n), .wr(wr_v[d]), .din(din_v[d]),
         .ack_tog(ack_v[d]), .word(word_v[d]), .req_tog(req_v[d])
      );

      mbox_rx #(.W(W), .STAGES(SYNC_STAGES)) u_rx (
         .clk(clk_v[RX]), .rst_n(rst_n), .rd(rd_v[RX]), .req_tog(req_v[d]),
         .word(word_v[d]), .ack_tog(ack_v[d]), .mail_n(mail_v[RX])
      );
   end

   assign dout_b   = word_v[DIR_A2B];
   assign dout_a   = word_v[DIR_B2A];
   assign mail_b_n = mail_v[1];
   assign mail_a_n = mail_v[0];
endmodule

// File: tb/mbox_pair_test.sv
module mbox_pair_test;
   localparam int unsigned W = 36;

   logic clk_a = 0, clk_b = 0, rst_n = 0;
   logic sel_a = 0, wr_a = 0, rd_a = 0, sel_b = 0, wr_b = 0, rd_b = 0;
   logic [W-1:0] din_a = '0, din_b = '0, dout_a, dout_b;
   logic mail_a_n, mail_b_n;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk_a = ~clk_a;   // 250 MHz
   always #4.5 clk_b = ~clk_b; // unrelated slower clock

   mbox_pair #(.W(W), .SYNC_STAGES(2)) uut (.*);

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wa(input logic s, input logic w, input logic r, input logic [W-1:0] d);
      @(negedge clk_a); sel_a = s; wr_a = w; rd_a = r; din_a = d;
      @(negedge clk_a); sel_a = 0; wr_a = 0; rd_a = 0;
   endtask
   task automatic wb(input logic s, input logic w, input logic r, input logic [W-1:0] d);
      @(negedge clk_b); sel_b = s; wr_b = w; rd_b = r; din_b = d;
      @(negedge clk_b); sel_b = 0; wr_b = 0; rd_b = 0;
   endtask
   task automatic na(input int n); repeat (n) @(negedge clk_a); endtask
   task automatic nb(input int n); repeat (n) @(negedge clk_b); endtask

   function automatic logic [W-1:0] pat(input int i);
      return 36'h9_8765_4321 ^ (W'(i) * 36'h1_2481_1357);
   endfunction

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #11;
      chk("R1 mail_a_n in reset", W'(mail_a_n), W'(1));
      chk("R1 mail_b_n in reset", W'(mail_b_n), W'(1));
      #3.3 rst_n = 1;
      nb(3);
      chk("R1 mail_a_n after reset", W'(mail_a_n), W'(1));
      chk("R1 mail_b_n after reset", W'(mail_b_n), W'(1));
      chk("R1 dout_a", dout_a, '0);
      chk("R1 dout_b", dout_b, '0);

      // R7: reads with no mail, then traffic must still work
      wb(1, 0, 1, '0); wa(1, 0, 1, '0); nb(4);
      chk("R7 idle read B", W'(mail_b_n), W'(1));
      chk("R7 idle read A", W'(mail_a_n), W'(1));

      // R6: strobes without select
      wa(0, 1, 0, pat(99)); wb(0, 1, 0, pat(98)); nb(4); na(4);
      chk("R6 no mail B", W'(mail_b_n), W'(1));
      chk("R6 no mail A", W'(mail_a_n), W'(1));
      chk("R6 dout_b", dout_b, '0);
      chk("R6 dout_a", dout_a, '0);

      for (int i = 0; i < 8; i++) begin
         // A to B
         wa(1, 1, 0, pat(i));
         chk("R2 flag not early", W'(mail_b_n), W'(1));
         nb(3);
         chk("R2 mail_b_n low", W'(mail_b_n), W'(0));
         chk("R2 dout_b", dout_b, pat(i));
         chk("R9 mail_a_n untouched", W'(mail_a_n), W'(1));
         wa(1, 1, 0, ~pat(i));                 // R4 busy write
         wb(0, 0, 1, '0);                      // R6 unselected read
         nb(2);
         chk("R8 flag held", W'(mail_b_n), W'(0));
         chk("R4 word kept", dout_b, pat(i));
         @(negedge clk_b); sel_b = 1; rd_b = 1;
         @(negedge clk_b); sel_b = 0; rd_b = 0;
         chk("R3 flag cleared", W'(mail_b_n), W'(1));
         nb(4);
         chk("R4 no new mail", W'(mail_b_n), W'(1));
         na(4);
         // B to A
         wb(1, 1, 0, pat(i + 20));
         na(4);
         chk("R5 mail_a_n low", W'(mail_a_n), W'(0));
         chk("R5 dout_a", dout_a, pat(i + 20));
         chk("R9 dout_b untouched", dout_b, pat(i));
         wb(1, 1, 0, ~pat(i));
         chk("R5 R4 word kept", dout_a, pat(i + 20));
         wa(1, 0, 1, '0);
         chk("R5 flag cleared", W'(mail_a_n), W'(1));
         na(4); nb(4);
         chk("R5 no new mail", W'(mail_a_n), W'(1));
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule